// File: doc/BRIEF.md
# Hybrid Cache-and-Associative Register Rename Unit

This block renames one instruction per cycle for a small out-of-order core. The authoritative logical-to-physical map is an associative table with one row per physical register. Each row records the logical register it currently backs and whether that binding is live. A direct-indexed cache with one entry per logical register sits in front of that table. Sources are looked up in the cache first. Only when the cache has no entry does a second pipeline stage search the associative table. That search stalls the front end for one cycle, and the result is then written back into the cache.

The destination register receives a physical register from a FIFO pool of free tags. The live binding it replaces is located associatively and reported as the previous mapping. The new binding goes into the cache and into the table in the same edge. Tags are returned to the pool through a separate port.

When a source that missed in the cache names the same register as its own instruction's destination, the table already holds the new binding by the time of the search. The unit therefore forwards the captured previous binding in that case.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i, the cache is empty, and the free pool holds tags NUM_LOG to NUM_PHYS-1 in ascending order. in_ready is high and out_valid is low.
- R2: When both sources hit in the cache, out_valid pulses in the cycle two clock edges after the accept edge. psrc1 and psrc2 then carry the mappings that were live before the instruction.
- R3: When either source misses, in_ready is low in the following cycle and out_valid rises three edges after the accept edge. The tags come from the associative search, and a later read of the same register hits.
- R4: pdst is the tag at the head of the free pool. A tag returned through free_valid/free_tag is appended at the tail. The unit keeps no destination equal to its replaced mapping.
- R5: pdst_old is the binding the destination replaced. Later sources naming that register return pdst, and every logical register has exactly one live row.
- R6: A source equal to its own instruction's destination returns the old binding, on both the cache-hit path and the cache-miss path.
- R7: With dst_en low, pdst and pdst_old read 0, no tag leaves the pool, and the map is unchanged.
- R8: While the pool is empty, in_ready stays low. It rises in the cycle after a tag is returned.
- R9: Back-to-back instructions are accepted on consecutive cycles when both hit, and a source naming the previous instruction's destination gets that instruction's pdst.
- R10: out_valid lasts one cycle per accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle if in_valid |
| src1 | input | LW | First source logical register |
| src2 | input | LW | Second source logical register |
| dst | input | LW | Destination logical register |
| dst_en | input | 1 | Instruction writes dst |
| free_valid | input | 1 | Return a tag to the pool |
| free_tag | input | TW | Tag being returned |
| out_valid | output | 1 | Renamed result valid |
| psrc1 | output | TW | Physical tag of src1 |
| psrc2 | output | TW | Physical tag of src2 |
| pdst | output | TW | Newly allocated tag, 0 without a destination |
| pdst_old | output | TW | Replaced tag, 0 without a destination |

## Verification
A renamed result is due two clock edges after the edge that accepts the instruction if both sources hit in the cache, and three edges after it if either missed. in_ready must already be low in the cycle right after a missing accept. The bench drives and samples on falling edges and counts falling edges from the accept until out_valid appears. It compares that count with the hit or miss latency predicted by its own model of cache occupancy, then checks the tags and that the pulse ends one cycle later. A back-to-back pair is checked at fixed falling edges, and the empty-pool stall is checked at the falling edge after the last pop and after the first return.

// File: rtl/rn_pkg.sv
// Shared definitions for the rename unit.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package rn_pkg;

    // Where a source tag in stage two came from.
    typedef enum logic [1:0] {
        SRC_RAM = 2'd0,
        SRC_CAM = 2'd1,
        SRC_FWD = 2'd2
    } src_path_e;

    // Index width for a table of n entries, at least one bit.
    function automatic int ptr_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rn_free_pool.sv
// FIFO of free physical register tags.
// Reset fills it with NUM_LOG..NUM_PHYS-1 in order. pop takes the head and push appends at the tail.
// Assumes: pop is only requested when not empty; a push into a full pool is dropped.
module rn_free_pool
    import rn_pkg::*;
#(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    localparam int TW      = ptr_bits(NUM_PHYS),
    localparam int CW      = $clog2(NUM_PHYS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [TW-1:0] push_tag,
    output logic [TW-1:0] head_tag,
    output logic          empty
);
    localparam int NFREE = NUM_PHYS - NUM_LOG;

    logic [TW-1:0] slot [NUM_PHYS];
    logic [TW-1:0] rd_ptr;
    logic [TW-1:0] wr_ptr;
    logic [CW-1:0] level;
    logic          pop_do;
    logic          push_do;

    // Wrap a pointer at the pool depth.
    function automatic logic [TW-1:0] bump(input logic [TW-1:0] p);
        return (p == TW'(NUM_PHYS - 1)) ? '0 : p + 1'b1;
    endfunction

    // Qualify requests against occupancy.
    always_comb begin
        pop_do  = pop && (level != '0);
        push_do = push && (level != CW'(NUM_PHYS));
    end

    assign head_tag = slot[rd_ptr];
    assign empty    = (level == '0);

    // Storage, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                slot[i] <= (i < NFREE) ? TW'(NUM_LOG + i) : '0;
            end
            rd_ptr <= '0;
            wr_ptr <= TW'(NFREE);
            level  <= CW'(NFREE);
        end else begin
            if (push_do) begin
                slot[wr_ptr] <= push_tag;
                wr_ptr       <= bump(wr_ptr);
            end
            if (pop_do) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push_do, pop_do})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/rn_map_ram.sv
// Direct-indexed mapping cache, one entry per logical register, holding a valid bit and a tag.
// It has two combinational read ports, two fill ports and one destination write port.
// The destination write wins over a fill to the same entry.
// Assumes: a cached tag is only ever written with the live binding.
module rn_map_ram
    import rn_pkg::*;
#(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    localparam int LW      = ptr_bits(NUM_LOG),
    localparam int TW      = ptr_bits(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_key   [2],
    output logic          rd_hit   [2],
    output logic [TW-1:0] rd_tag   [2],
    input  logic          fill_en  [2],
    input  logic [LW-1:0] fill_key [2],
    input  logic [TW-1:0] fill_tag [2],
    input  logic          wr_en,
    input  logic [LW-1:0] wr_key,
    input  logic [TW-1:0] wr_tag
);
    logic          ent_valid [NUM_LOG];
    logic [TW-1:0] ent_tag   [NUM_LOG];

    for (genvar k = 0; k < 2; k++) begin : g_rd
        // Read port k.
        assign rd_hit[k] = ent_valid[rd_key[k]];
        assign rd_tag[k] = ent_tag[rd_key[k]];
    end

    // Entry updates: fills first, destination write last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_LOG; e++) begin
                ent_valid[e] <= 1'b0;
                ent_tag[e]   <= '0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (fill_en[k]) begin
                    ent_valid[fill_key[k]] <= 1'b1;
                    ent_tag[fill_key[k]]   <= fill_tag[k];
                end
            end
            if (wr_en) begin
                ent_valid[wr_key] <= 1'b1;
                ent_tag[wr_key]   <= wr_tag;
            end
        end
    end
endmodule

// File: rtl/rn_map_cam.sv
// Authoritative associative map with one row per physical register.
// Each row holds the logical register it backs and a live bit.
// NUM_KEYS parallel search ports return the lowest matching live row.
// An update kills every live row of the logical register and makes the given row live for it.
// Assumes: the updated row is not live when the update arrives.
module rn_map_cam
    import rn_pkg::*;
#(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    parameter int NUM_KEYS = 3,
    localparam int LW      = ptr_bits(NUM_LOG),
    localparam int TW      = ptr_bits(NUM_PHYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LW-1:0]       key     [NUM_KEYS],
    output logic                key_hit [NUM_KEYS],
    output logic [TW-1:0]       key_row [NUM_KEYS],
    input  logic                upd_en,
    input  logic [LW-1:0]       upd_lreg,
    input  logic [TW-1:0]       upd_row,
    output logic [NUM_PHYS-1:0] row_valid
);
    logic [LW-1:0] row_lreg [NUM_PHYS];

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        logic          hit_l;
        logic [TW-1:0] row_l;
        // Priority search, lowest row wins.
        always_comb begin
            hit_l = 1'b0;
            row_l = '0;
            for (int r = NUM_PHYS - 1; r >= 0; r--) begin
                if (row_valid[r] && (row_lreg[r] == key[k])) begin
                    hit_l = 1'b1;
                    row_l = TW'(r);
                end
            end
        end
        assign key_hit[k] = hit_l;
        assign key_row[k] = row_l;
    end

    // Row state: identity map at reset, kill-and-set on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_PHYS; r++) begin
                row_valid[r] <= (r < NUM_LOG);
                row_lreg[r]  <= (r < NUM_LOG) ? LW'(r) : '0;
            end
        end else if (upd_en) begin
            for (int r = 0; r < NUM_PHYS; r++) begin
                if (TW'(r) == upd_row) begin
                    row_valid[r] <= 1'b1;
                    row_lreg[r]  <= upd_lreg;
                end else if (row_lreg[r] == upd_lreg) begin
                    row_valid[r] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rn_rename_unit.sv
// Single-issue rename unit with a mapping cache in front of an associative map.
// Accept cycle: read the cache for both sources, search the map for the destination's current
// binding, pop a free tag, and commit the new binding to cache and map at the edge.
// Stage two: if a source missed, search the map for one cycle with in_ready held low.
// A source equal to the instruction's own destination takes the captured previous binding.
// Results are registered and leave as a one-cycle out_valid pulse.
// Assumes: a returned tag is not live in the map.
module rn_rename_unit
    import rn_pkg::*;
#(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    localparam int LW      = ptr_bits(NUM_LOG),
    localparam int TW      = ptr_bits(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [LW-1:0] src1,
    input  logic [LW-1:0] src2,
    input  logic [LW-1:0] dst,
    input  logic          dst_en,
    input  logic          free_valid,
    input  logic [TW-1:0] free_tag,
    output logic          out_valid,
    output logic [TW-1:0] psrc1,
    output logic [TW-1:0] psrc2,
    output logic [TW-1:0] pdst,
    output logic [TW-1:0] pdst_old
);
    // Pool
    logic          pool_pop;
    logic [TW-1:0] pool_head;
    logic          pool_empty;

    // Cache
    logic [LW-1:0] ram_rd_key   [2];
    logic          ram_rd_hit   [2];
    logic [TW-1:0] ram_rd_tag   [2];
    logic          ram_fill_en  [2];
    logic [LW-1:0] ram_fill_key [2];
    logic [TW-1:0] ram_fill_tag [2];
    logic          hit_both;

    // Map
    logic [LW-1:0]       cam_key     [3];
    logic                cam_key_hit [3];
    logic [TW-1:0]       cam_key_row [3];
    logic [NUM_PHYS-1:0] cam_row_valid;

    // Stage two
    logic          s2_valid;
    logic          s2_pend;
    logic [LW-1:0] s2_src  [2];
    logic [TW-1:0] s2_tag  [2];
    src_path_e     s2_path [2];
    logic [LW-1:0] s2_dst;
    logic          s2_dst_en;
    logic [TW-1:0] s2_pdst;
    logic [TW-1:0] s2_pold;

    logic          lane_need [2];
    logic [TW-1:0] lane_tag  [2];
    src_path_e     lane_path [2];

    logic accept;
    logic commit_dst;

    // Handshake: stall on an unresolved miss or an empty pool.
    always_comb begin
        in_ready   = !pool_empty && !(s2_valid && s2_pend);
        accept     = in_valid && in_ready;
        commit_dst = accept && dst_en;
        pool_pop   = commit_dst;
        hit_both   = ram_rd_hit[0] && ram_rd_hit[1];
    end

    assign ram_rd_key[0] = src1;
    assign ram_rd_key[1] = src2;
    assign cam_key[0]    = dst;
    assign cam_key[1]    = s2_src[0];
    assign cam_key[2]    = s2_src[1];

    rn_free_pool #(
        .NUM_LOG  (NUM_LOG),
        .NUM_PHYS (NUM_PHYS)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (pool_pop),
        .push     (free_valid),
        .push_tag (free_tag),
        .head_tag (pool_head),
        .empty    (pool_empty)
    );

    rn_map_ram #(
        .NUM_LOG  (NUM_LOG),
        .NUM_PHYS (NUM_PHYS)
    ) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_key   (ram_rd_key),
        .rd_hit   (ram_rd_hit),
        .rd_tag   (ram_rd_tag),
        .fill_en  (ram_fill_en),
        .fill_key (ram_fill_key),
        .fill_tag (ram_fill_tag),
        .wr_en    (commit_dst),
        .wr_key   (dst),
        .wr_tag   (pool_head)
    );

    rn_map_cam #(
        .NUM_LOG  (NUM_LOG),
        .NUM_PHYS (NUM_PHYS),
        .NUM_KEYS (3)
    ) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .key       (cam_key),
        .key_hit   (cam_key_hit),
        .key_row   (cam_key_row),
        .upd_en    (commit_dst),
        .upd_lreg  (dst),
        .upd_row   (pool_head),
        .row_valid (cam_row_valid)
    );

    for (genvar k = 0; k < 2; k++) begin : g_lane
        logic own_dst;
        // Miss resolution for source lane k, with forwarding of the replaced binding.
        always_comb begin
            own_dst         = s2_dst_en && (s2_src[k] == s2_dst);
            lane_need[k]    = s2_valid && s2_pend && (s2_path[k] == SRC_CAM);
            ram_fill_en[k]  = lane_need[k] && !own_dst && cam_key_hit[k+1];
            ram_fill_key[k] = s2_src[k];
            ram_fill_tag[k] = cam_key_row[k+1];
            lane_tag[k]     = own_dst ? s2_pold
                                      : (cam_key_hit[k+1] ? cam_key_row[k+1] : '0);
            lane_path[k]    = own_dst ? SRC_FWD : SRC_CAM;
        end
    end

    // Stage-two register: load on accept, resolve a miss, or drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_pend   <= 1'b0;
            s2_dst    <= '0;
            s2_dst_en <= 1'b0;
            s2_pdst   <= '0;
            s2_pold   <= '0;
            for (int k = 0; k < 2; k++) begin
                s2_src[k]  <= '0;
                s2_tag[k]  <= '0;
                s2_path[k] <= SRC_RAM;
            end
        end else if (accept) begin
            s2_valid  <= 1'b1;
            s2_pend   <= !hit_both;
            s2_dst    <= dst;
            s2_dst_en <= dst_en;
            s2_pdst   <= dst_en ? pool_head : '0;
            s2_pold   <= (dst_en && cam_key_hit[0]) ? cam_key_row[0] : '0;
            for (int k = 0; k < 2; k++) begin
                s2_src[k]  <= ram_rd_key[k];
                s2_tag[k]  <= ram_rd_tag[k];
                s2_path[k] <= ram_rd_hit[k] ? SRC_RAM : SRC_CAM;
            end
        end else if (s2_valid && s2_pend) begin
            s2_pend <= 1'b0;
            for (int k = 0; k < 2; k++) begin
                if (lane_need[k]) begin
                    s2_tag[k]  <= lane_tag[k];
                    s2_path[k] <= lane_path[k];
                end
            end
        end else begin
            s2_valid <= 1'b0;
        end
    end

    // Output register: one pulse per resolved instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            psrc1     <= '0;
            psrc2     <= '0;
            pdst      <= '0;
            pdst_old  <= '0;
        end else begin
            out_valid <= s2_valid && !s2_pend;
            if (s2_valid && !s2_pend) begin
                psrc1    <= s2_tag[0];
                psrc2    <= s2_tag[1];
                pdst     <= s2_pdst;
                pdst_old <= s2_pold;
            end
        end
    end
endmodule

// File: rtl/rn_rename_chk.sv
// Temporal checks on the rename unit, attached by bind.
// Assumes: the bench returns only tags that are not live.
module rn_rename_chk
    import rn_pkg::*;
#(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    localparam int TW      = ptr_bits(NUM_PHYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                accept,
    input logic                hit_both,
    input logic                in_ready,
    input logic                s2_valid,
    input logic                s2_pend,
    input logic                s2_dst_en,
    input logic [TW-1:0]       s2_pdst,
    input logic [TW-1:0]       s2_pold,
    input logic                out_valid,
    input logic [NUM_PHYS-1:0] cam_row_valid
);
    // R2
    hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_both) |-> ##2 out_valid);

    // R3
    miss_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit_both) |-> ##3 out_valid);

    // R3
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit_both) |=> !in_ready);

    // R3
    miss_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_pend) |=> (s2_valid && !s2_pend));

    // R5
    live_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cam_row_valid) == NUM_LOG);

    // R4
    fresh_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_dst_en) |-> (s2_pdst != s2_pold));
endmodule

bind rn_rename_unit rn_rename_chk #(
    .NUM_LOG  (NUM_LOG),
    .NUM_PHYS (NUM_PHYS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .hit_both      (hit_both),
    .in_ready      (in_ready),
    .s2_valid      (s2_valid),
    .s2_pend       (s2_pend),
    .s2_dst_en     (s2_dst_en),
    .s2_pdst       (s2_pdst),
    .s2_pold       (s2_pold),
    .out_valid     (out_valid),
    .cam_row_valid (cam_row_valid)
);

// File: tb/rn_rename_unit_test.sv
// Self-checking bench: model of map, cache occupancy and free FIFO.
module rn_rename_unit_test;
    localparam int NL = 8;
    localparam int NP = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] src1 = '0;
    logic [2:0] src2 = '0;
    logic [2:0] dst = '0;
    logic       dst_en = 1'b0;
    logic       free_valid = 1'b0;
    logic [3:0] free_tag = '0;
    logic       out_valid;
    logic [3:0] psrc1, psrc2, pdst, pdst_old;

    int checks = 0;
    int fails = 0;
    int m_map [NL];
    bit m_rv [NL];
    int pool_q [$];
    int olds [$];

    always #5 clk = ~clk;

    rn_rename_unit #(.NUM_LOG(NL), .NUM_PHYS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src1(src1), .src2(src2), .dst(dst), .dst_en(dst_en),
        .free_valid(free_valid), .free_tag(free_tag),
        .out_valid(out_valid), .psrc1(psrc1), .psrc2(psrc2),
        .pdst(pdst), .pdst_old(pdst_old)
    );

    task automatic report_end();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_free(input int t);
        free_valid = 1'b1;
        free_tag   = 4'(t);
        @(posedge clk);
        @(negedge clk);
        free_valid = 1'b0;
        pool_q.push_back(t);
    endtask

    // One instruction, fully checked; called at a falling edge.
    task automatic do_rename(input int a, input int b, input int d, input bit den,
                             output int old_tag);
        int  e1, e2, ep, eo, n;
        bit  miss;
        e1   = m_map[a];
        e2   = m_map[b];
        miss = !m_rv[a] || !m_rv[b];
        ep   = 0;
        eo   = 0;
        if (den) begin
            ep = pool_q[0];
            eo = m_map[d];
        end
        n = 0;
        while (!in_ready && n < 20) begin
            @(negedge clk);
            n++;
        end
        src1 = 3'(a); src2 = 3'(b); dst = 3'(d); dst_en = den; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        dst_en   = 1'b0;
        m_rv[a] = 1'b1;
        m_rv[b] = 1'b1;
        if (den) begin
            void'(pool_q.pop_front());
            m_map[d] = ep;
            m_rv[d]  = 1'b1;
        end
        if (miss) check(in_ready == 1'b0, "R3", "in_ready in miss cycle", int'(in_ready), 0);
        n = 1;
        while (!out_valid && n < 8) begin
            @(negedge clk);
            n++;
        end
        check(n == (miss ? 3 : 2), miss ? "R3" : "R2", "latency", n, miss ? 3 : 2);
        check(int'(psrc1) == e1, (den && a == d) ? "R6" : (miss ? "R3" : "R2"), "psrc1", int'(psrc1), e1);
        check(int'(psrc2) == e2, (den && b == d) ? "R6" : (miss ? "R3" : "R2"), "psrc2", int'(psrc2), e2);
        check(int'(pdst) == ep, den ? "R4" : "R7", "pdst", int'(pdst), ep);
        check(int'(pdst_old) == eo, den ? "R5" : "R7", "pdst_old", int'(pdst_old), eo);
        @(negedge clk);
        check(out_valid == 1'b0, "R10", "pulse width", int'(out_valid), 0);
        old_tag = eo;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report_end();
    end

    initial begin
        int old_tag, pa, pb, oa, ob;
        for (int i = 0; i < NL; i++) begin
            m_map[i] = i;
            m_rv[i]  = 1'b0;
        end
        for (int i = NL; i < NP; i++) pool_q.push_back(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        // R1 identity mapping and first pool tag, constants
        do_rename(3, 4, 7, 1'b1, old_tag);
        check(psrc1 == 4'd3 && psrc2 == 4'd4, "R1", "identity sources", int'(psrc1), 3);
        check(pdst == 4'd8 && pdst_old == 4'd7, "R1", "first pool tag", int'(pdst), 8);
        do_free(old_tag);
        // R3 refill: the register filled by the miss now hits
        do_rename(3, 3, 0, 1'b0, old_tag);

        // Sweep over all source pairs, mixed destinations, R6 and R7 included
        for (int a = 0; a < NL; a++) begin
            for (int b = 0; b < NL; b++) begin
                int  d;
                bit  den;
                d   = (a * 3 + b) % NL;
                den = ((a + b) % 3) != 0;
                do_rename(a, b, d, den, old_tag);
                if (den) do_free(old_tag);
            end
        end

        // R9 back-to-back pair, all cached by now
        pa = pool_q[0];
        pb = pool_q[1];
        oa = m_map[5];
        ob = m_map[6];
        src1 = 3'd1; src2 = 3'd2; dst = 3'd5; dst_en = 1'b1; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "ready after hit", int'(in_ready), 1);
        src1 = 3'd5; src2 = 3'd5; dst = 3'd6; dst_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; dst_en = 1'b0;
        check(out_valid == 1'b1 && int'(pdst) == pa, "R9", "first of pair pdst", int'(pdst), pa);
        @(negedge clk);
        check(out_valid == 1'b1 && int'(psrc1) == pa && int'(psrc2) == pa, "R9",
              "forwarded source", int'(psrc1), pa);
        check(int'(pdst) == pb && int'(pdst_old) == ob, "R9", "second of pair pdst", int'(pdst), pb);
        void'(pool_q.pop_front());
        void'(pool_q.pop_front());
        m_map[5] = pa;
        m_map[6] = pb;
        @(negedge clk);
        do_free(oa);
        do_free(ob);

        // R8 drain the pool
        while (pool_q.size() > 0) begin
            int k;
            k = pool_q.size() % NL;
            do_rename(k, (k + 1) % NL, k, 1'b1, old_tag);
            olds.push_back(old_tag);
        end
        check(in_ready == 1'b0, "R8", "ready with empty pool", int'(in_ready), 0);
        @(negedge clk);
        check(in_ready == 1'b0, "R8", "ready stays low", int'(in_ready), 0);
        pa = olds.pop_front();
        do_free(pa);
        check(in_ready == 1'b1, "R8", "ready after return", int'(in_ready), 1);
        // R4 returned tag comes out next
        do_rename(2, 3, 1, 1'b1, old_tag);
        check(int'(pdst) == pa, "R4", "returned tag reused", int'(pdst), pa);
        olds.push_back(old_tag);
        while (olds.size() > 0) do_free(olds.pop_front());
        do_rename(0, 7, 4, 1'b1, old_tag);

        report_end();
    end
endmodule